// File: doc/BRIEF.md
# Masked Status Condition Evaluator

This unit decides, for the command a channel sequencer is finishing, whether the channel should raise an interrupt, take a branch, or hold and wait. Each of the three decisions has its own 2-bit policy field in the command word and its own select register. A select register holds a 4-bit mask and a 4-bit compare value. The device-status bits of the channel are compared with the select register under that mask, and the policy then turns the result of the comparison into a decision.

The sequencer pulses `eval_req` for one cycle when it wants a verdict. One cycle later `eval_done` pulses and the three decision outputs carry the result. The decision outputs keep that value until the next request. A wait verdict overrides the other two, so a waiting command neither interrupts nor branches. A positive interrupt verdict sets a sticky interrupt request line. The line stays high until the interrupt handler pulses `irq_clr`.

Top module: `status_cond_eval`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `eval_done`, `do_intr`, `do_branch`, `do_wait` and `irq` are all 0.
- R2: A purpose's condition is true when `(dev_status & mask) == (value & mask)`, where mask is bits 19:16 of that purpose's select word and value is bits 3:0. No other bit of a select word, and no bit of `cmd_word` above bit 5, affects any output.
- R3: Policy fields sit in `cmd_word` at bits 5:4 for interrupt, bits 3:2 for branch and bits 1:0 for wait. The codes are 0 = never, 1 = when the condition is true, 2 = when the condition is false, 3 = always.
- R4: Each decision uses only its own select word: `intr_sel` for interrupt, `branch_sel` for branch and `wait_sel` for wait.
- R5: The decisions for a request made in cycle k appear in cycle k+1, together with a one-cycle `eval_done` pulse.
- R6: When the wait decision is 1, `do_intr` and `do_branch` are both 0 for that request, and `irq` is not set by it.
- R7: A request whose interrupt decision is 1 sets `irq` in cycle k+1. `irq` then stays 1 until a cycle in which `irq_clr` is 1, and it is 0 in the cycle after that.
- R8: If `irq_clr` is 1 in the same cycle as a request whose interrupt decision is 1, `irq` ends up 1: the new event wins over the clear.
- R9: In cycles without `eval_req`, the three decision outputs keep their values even when the other inputs change, and `eval_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_req | input | 1 | One-cycle request to evaluate the current command |
| cmd_word | input | 16 | Command word holding the three policy fields |
| dev_status | input | 4 | Device-status bits of the channel |
| intr_sel | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| branch_sel | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel | input | 32 | Wait select word (mask 19:16, value 3:0) |
| irq_clr | input | 1 | Clear pulse for the interrupt request |
| eval_done | output | 1 | Pulses one cycle after a request |
| do_intr | output | 1 | Interrupt decision |
| do_branch | output | 1 | Branch decision |
| do_wait | output | 1 | Wait decision |
| irq | output | 1 | Sticky interrupt request |

## Verification
All 64 combinations of the three policy codes are swept twice: once with every condition true and once with every condition false. This sweep tells the if-true code apart from the if-false code and separates never from always. A phase with random select words and random command upper bits, including zero masks and full masks, shows whether stray bits leak into the comparison. A phase in which the three select words disagree shows whether a decision reads the wrong register. Directed sequences cover the following cases:
- wait overriding the interrupt and branch decisions;
- a long idle stretch during which `irq` must stay set;
- a clear arriving in the same cycle as a new interrupt event;
- requests withheld while the other inputs change, which shows that the decisions are held.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  typedef enum logic [1:0] {
    POL_NEVER    = 2'd0,
    POL_IF_MATCH = 2'd1,
    POL_IF_MISS  = 2'd2,
    POL_ALWAYS   = 2'd3
  } policy_e;

  localparam int NUM_PURPOSE = 3;
  localparam int P_INTR      = 0;
  localparam int P_BRANCH    = 1;
  localparam int P_WAIT      = 2;
endpackage

// File: rtl/sel_match.sv
module sel_match #(
  parameter int STAT_W   = 4,
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16
) (
  input  logic [SEL_W-1:0]  sel_word,
  input  logic [STAT_W-1:0] status,
  output logic              hit
);
  logic [STAT_W-1:0] mask;
  logic [STAT_W-1:0] value;

  always_comb begin
    mask  = sel_word[MASK_LSB +: STAT_W];
    value = sel_word[STAT_W-1:0];
    hit   = ((status & mask) == (value & mask));
  end
endmodule

// File: rtl/policy_pick.sv
module policy_pick
  import cond_eval_pkg::*;
(
  input  policy_e policy,
  input  logic    hit,
  output logic    fire
);
  always_comb begin
    unique case (policy)
      POL_NEVER:    fire = 1'b0;
      POL_IF_MATCH: fire = hit;
      POL_IF_MISS:  fire = ~hit;
      POL_ALWAYS:   fire = 1'b1;
      default:      fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_hold.sv
module irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (set_req)      irq_d = 1'b1;
    else if (clr_req) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/status_cond_eval.sv
module status_cond_eval
  import cond_eval_pkg::*;
#(
  parameter int STAT_W   = 4,
  parameter int SEL_W    = 32,
  parameter int MASK_LSB = 16,
  parameter int CMD_W    = 16,
  parameter int POL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_req,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [STAT_W-1:0] dev_status,
  input  logic [SEL_W-1:0]  intr_sel,
  input  logic [SEL_W-1:0]  branch_sel,
  input  logic [SEL_W-1:0]  wait_sel,
  input  logic              irq_clr,
  output logic              eval_done,
  output logic              do_intr,
  output logic              do_branch,
  output logic              do_wait,
  output logic              irq
);
  localparam int FIELDS_W = POL_W * NUM_PURPOSE;

  logic [SEL_W-1:0]       sel_arr [NUM_PURPOSE];
  logic [NUM_PURPOSE-1:0] hit_v;
  logic [NUM_PURPOSE-1:0] fire_v;
  logic [FIELDS_W-1:0]    fields;

  logic intr_d, branch_d, wait_d, done_d;
  logic intr_q, branch_q, wait_q, done_q;

  always_comb begin
    sel_arr[P_INTR]   = intr_sel;
    sel_arr[P_BRANCH] = branch_sel;
    sel_arr[P_WAIT]   = wait_sel;
    fields            = cmd_word[FIELDS_W-1:0];
  end

  // Interrupt owns the top field, wait the bottom one.
  for (genvar p = 0; p < NUM_PURPOSE; p++) begin : g_purpose
    localparam int LSB = POL_W * (NUM_PURPOSE - 1 - p);
    policy_e pol;
    assign pol = policy_e'(fields[LSB +: POL_W]);

    sel_match #(
      .STAT_W(STAT_W), .SEL_W(SEL_W), .MASK_LSB(MASK_LSB)
    ) u_match (
      .sel_word(sel_arr[p]),
      .status  (dev_status),
      .hit     (hit_v[p])
    );

    policy_pick u_pick (
      .policy(pol),
      .hit   (hit_v[p]),
      .fire  (fire_v[p])
    );
  end

  always_comb begin
    done_d   = eval_req;
    wait_d   = wait_q;
    intr_d   = intr_q;
    branch_d = branch_q;
    if (eval_req) begin
      wait_d   = fire_v[P_WAIT];
      intr_d   = fire_v[P_INTR]   & ~fire_v[P_WAIT];
      branch_d = fire_v[P_BRANCH] & ~fire_v[P_WAIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      wait_q   <= 1'b0;
      intr_q   <= 1'b0;
      branch_q <= 1'b0;
    end else begin
      done_q   <= done_d;
      wait_q   <= wait_d;
      intr_q   <= intr_d;
      branch_q <= branch_d;
    end
  end

  irq_hold u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(eval_req & intr_d),
    .clr_req(irq_clr),
    .irq    (irq)
  );

  assign eval_done = done_q;
  assign do_intr   = intr_q;
  assign do_branch = branch_q;
  assign do_wait   = wait_q;
endmodule

// File: rtl/status_cond_eval_chk.sv
module status_cond_eval_chk #(
  parameter int CMD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eval_req,
  input logic [CMD_W-1:0] cmd_word,
  input logic             irq_clr,
  input logic             eval_done,
  input logic             do_intr,
  input logic             do_branch,
  input logic             do_wait,
  input logic             irq
);
  assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |=> eval_done);

  assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !eval_done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> ($stable(do_intr) && $stable(do_branch) && $stable(do_wait)));

  assert_wait_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_wait |-> (!do_intr && !do_branch));

  assert_never_intr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && cmd_word[5:4] == 2'd0) |=> !do_intr);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !eval_req) |=> !irq);

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (eval_done && do_intr));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && do_intr && $rose(eval_done)) |-> irq);
endmodule

bind status_cond_eval status_cond_eval_chk #(.CMD_W(CMD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eval_req (eval_req),
  .cmd_word (cmd_word),
  .irq_clr  (irq_clr),
  .eval_done(eval_done),
  .do_intr  (do_intr),
  .do_branch(do_branch),
  .do_wait  (do_wait),
  .irq      (irq)
);

// File: tb/sim_status_cond_eval.sv
`timescale 1ns/1ps
module sim_status_cond_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_req;
  logic [15:0] cmd_word;
  logic [3:0]  dev_status;
  logic [31:0] intr_sel, branch_sel, wait_sel;
  logic        irq_clr;
  logic        eval_done, do_intr, do_branch, do_wait, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  // reference state
  bit m_done, m_intr, m_branch, m_wait, m_irq;

  always #4 clk = ~clk;

  status_cond_eval u0 (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .cmd_word(cmd_word),
    .dev_status(dev_status), .intr_sel(intr_sel), .branch_sel(branch_sel),
    .wait_sel(wait_sel), .irq_clr(irq_clr), .eval_done(eval_done),
    .do_intr(do_intr), .do_branch(do_branch), .do_wait(do_wait), .irq(irq)
  );

  function automatic bit cond_true(input logic [3:0] st, input logic [31:0] sel);
    int m, v;
    m = (sel >> 16) & 15;
    v = sel & 15;
    return ((st & m) == (v & m));
  endfunction

  function automatic bit decide(input int code, input bit c);
    if (code == 0) return 0;
    if (code == 1) return c;
    if (code == 2) return !c;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_intr = 0; m_branch = 0; m_wait = 0; m_irq = 0;
    end else begin
      bit w, i, b;
      w = decide((cmd_word >> 0) & 3, cond_true(dev_status, wait_sel));
      i = decide((cmd_word >> 4) & 3, cond_true(dev_status, intr_sel)) && !w;
      b = decide((cmd_word >> 2) & 3, cond_true(dev_status, branch_sel)) && !w;
      m_done = eval_req;
      if (eval_req) begin
        m_wait = w; m_intr = i; m_branch = b;
      end
      if (eval_req && i) m_irq = 1;
      else if (irq_clr)  m_irq = 0;
    end
  end

  task automatic cmp(input string name, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", phase, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    cmp("eval_done", eval_done, m_done);
    cmp("do_intr",   do_intr,   m_intr);
    cmp("do_branch", do_branch, m_branch);
    cmp("do_wait",   do_wait,   m_wait);
    cmp("irq",       irq,       m_irq);
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit ev, input logic [15:0] cw, input logic [3:0] st,
                      input logic [31:0] is, input logic [31:0] bs,
                      input logic [31:0] ws, input bit clr);
    @(negedge clk); #1;
    eval_req = ev; cmd_word = cw; dev_status = st;
    intr_sel = is; branch_sel = bs; wait_sel = ws; irq_clr = clr;
  endtask

  initial begin
    rst_n = 1'b0; eval_req = 0; cmd_word = 0; dev_status = 0;
    intr_sel = 0; branch_sel = 0; wait_sel = 0; irq_clr = 0;
    // R1: reset state held over several cycles
    phase = "R1";
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 16'h0, 4'h0, 0, 0, 0, 0);

    // R3: every policy combination, conditions all true, then all false
    phase = "R3";
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 64; c++) begin
        logic [31:0] s;
        s = (pass == 0) ? 32'h000F_0005 : 32'h000F_000A;
        step(1, 16'(c), 4'h5, s, s, s, 0);
        step(0, 16'(c), 4'h5, s, s, s, 1);
      end
    end

    // R2: random select words and command upper bits
    phase = "R2";
    for (int n = 0; n < 400; n++) begin
      step(1, 16'($urandom), 4'($urandom), $urandom, $urandom, $urandom, 1'($urandom));
      if (n % 50 == 0)
        step(1, 16'($urandom), 4'($urandom), 32'hFFF0_FFF0 | (32'($urandom) & 32'h000F_000F),
             32'hFFF0_FFF0, 32'h0000_FFFF, 0);
    end

    // R4: select words disagree; intr=if-true, branch=if-true, wait=if-true
    phase = "R4";
    step(1, 16'b01_01_01, 4'h3, 32'h000F_0003, 32'h000F_000C, 32'h000F_0000, 0);
    step(1, 16'b01_01_01, 4'h3, 32'h000F_000C, 32'h000F_0003, 32'h000F_0000, 1);
    step(1, 16'b01_01_01, 4'h3, 32'h000F_000C, 32'h000F_000C, 32'h0003_0003, 1);
    step(0, 16'h0, 4'h0, 0, 0, 0, 1);

    // R6: wait always overrides interrupt and branch always
    phase = "R6";
    step(1, 16'b11_11_11, 4'h0, 0, 0, 0, 0);
    step(0, 16'b11_11_11, 4'h0, 0, 0, 0, 0);

    // R7: set, hold through idle, then clear
    phase = "R7";
    step(1, 16'b11_00_00, 4'h0, 0, 0, 0, 0);
    for (int n = 0; n < 20; n++) step(0, 16'($urandom), 4'($urandom), $urandom, $urandom, $urandom, 0);
    step(0, 16'h0, 4'h0, 0, 0, 0, 1);
    step(0, 16'h0, 4'h0, 0, 0, 0, 0);

    // R8: clear in the same cycle as a new interrupt event
    phase = "R8";
    step(1, 16'b11_00_00, 4'h0, 0, 0, 0, 1);
    step(0, 16'h0, 4'h0, 0, 0, 0, 0);
    step(1, 16'b11_00_00, 4'h0, 0, 0, 0, 1);
    step(0, 16'h0, 4'h0, 0, 0, 0, 0);

    // R9: decisions held while requests are withheld
    phase = "R9";
    step(1, 16'b01_10_00, 4'h1, 32'h000F_0001, 32'h000F_0001, 0, 1);
    for (int n = 0; n < 30; n++)
      step(0, 16'($urandom), 4'($urandom), $urandom, $urandom, $urandom, 0);

    // R5: back-to-back requests
    phase = "R5";
    for (int n = 0; n < 30; n++)
      step(1, 16'($urandom), 4'($urandom), $urandom, $urandom, $urandom, 1'($urandom));
    step(0, 16'h0, 4'h0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule